// File: doc/BRIEF.md
# Sector Signature Threshold Checker

This block decides whether the bytes read back from a disk sector carry an expected signature. Each attempt is one run of bytes on a valid-qualified byte input. A leading region is not examined. A short run of fill bytes must then match a constant exactly. After that, a window of bytes is scanned and the zero bits in it are counted. Because the window is judged on its zero count against a threshold, and not byte by byte, a few stray one bits caused by clock drift on the medium are tolerated.

The expected fill constant is picked by a mode input, which is captured when a start strobe opens a search. A search runs several attempts on each of a range of track numbers. The first attempt that passes ends the search with a pass. If every attempt on every track fails, the search ends with a fail. The current track and attempt number are visible at the ports, so that the logic that fetches the bytes can follow the search.

Top module: `sig_threshold_checker`

## Requirements
- R1: After reset, and in the cycle after `start`, `done`, `pass` and `fail` are low, `track_no` is 7 and `try_no` is 0. Bytes offered before the first `start` are not consumed.
- R2: Bytes 0 to 63 of every attempt are not examined, whatever their values.
- R3: Bytes 64 to 79 must each equal the fill value. The fill value is 8'hFF when `mode_clk` was 0 at `start` and 8'h00 when it was 1. The first byte that differs ends the attempt as failed at once, and the next valid byte is byte 0 of the following attempt.
- R4: The cleared bits of bytes 80 to 111 (256 bits) are counted. The attempt passes when the count is 204 or more and fails when it is 203 or less.
- R5: A passing attempt sets `done` and `pass`, leaves `fail` low, and keeps `track_no` and `try_no` at the values of the passing attempt.
- R6: A failed attempt increments `try_no`. The fifth failure on a track instead resets `try_no` to 0 and increments `track_no`.
- R7: The fifth failure on track 10 ends the search with `done` and `fail` high and `pass` low.
- R8: Once `done` is high, it stays high with unchanged `pass`, `fail`, `track_no` and `try_no` until the next `start`. Bytes offered in that time have no effect.
- R9: `mode_clk` is only sampled at `start`. Changes to it during a search do not alter the fill value.
- R10: `pass` and `fail` are never high together, and `done` is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that clears the checker and opens a new search |
| mode_clk | input | 1 | Fill select captured at start: 0 expects 8'hFF, 1 expects 8'h00 |
| in_valid | input | 1 | `in_byte` carries a sector byte this cycle |
| in_byte | input | 8 | Sector byte |
| done | output | 1 | Search finished |
| pass | output | 1 | Search finished with a matching attempt |
| fail | output | 1 | Search finished with all attempts failed |
| track_no | output | 4 | Track of the current or final attempt (7 to 10) |
| try_no | output | 3 | Attempt index on the current track (0 to 4) |

## Verification
The hardest state to reach from the ports is the final failure. It needs twenty failed attempts in a row, each of at least 65 bytes. The bench reaches it cheaply by ending each attempt with a wrong fill byte straight after the ignored region. Along the way it checks the track roll-over after the fifth failure. The zero-count threshold is probed one bit below and exactly at 204, with window bytes built to carry an exact number of cleared bits. The byte right after an abort is treated as the start of a new full attempt, and that attempt must pass.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;

    typedef enum logic [1:0] {
        PH_SKIP = 2'd0,
        PH_FILL = 2'd1,
        PH_WIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic fin;
        logic ok;
    } verdict_t;

    function automatic logic [3:0] zero_bits(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            if (!b[i]) n = n + 4'd1;
        end
        return n;
    endfunction

    function automatic logic [7:0] fill_value(input logic clk_mode);
        return clk_mode ? 8'h00 : 8'hFF;
    endfunction

endpackage

// File: rtl/sig_window_scan.sv
module sig_window_scan
    import sigchk_pkg::*;
#(
    parameter int SKIP_BYTES = 64,
    parameter int FILL_BYTES = 16,
    parameter int WIN_BYTES  = 32,
    parameter int MIN_ZEROS  = 204
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  logic     en,
    input  logic     in_valid,
    input  logic [7:0] in_byte,
    input  logic [7:0] fill,
    output verdict_t verdict
);
    localparam int TOTAL = SKIP_BYTES + FILL_BYTES + WIN_BYTES;
    localparam int POS_W = $clog2(TOTAL);
    localparam int ZW    = $clog2(WIN_BYTES * 8 + 1);

    logic [POS_W-1:0] pos;
    logic [ZW-1:0]    zcnt;
    logic [ZW-1:0]    zsum;
    phase_e           phase;

    always_comb begin
        if (int'(pos) < SKIP_BYTES)
            phase = PH_SKIP;
        else if (int'(pos) < SKIP_BYTES + FILL_BYTES)
            phase = PH_FILL;
        else
            phase = PH_WIN;
        zsum = zcnt + ZW'(zero_bits(in_byte));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos     <= '0;
            zcnt    <= '0;
            verdict <= '0;
        end else begin
            verdict <= '0;
            if (en && in_valid) begin
                unique case (phase)
                    PH_SKIP: pos <= pos + POS_W'(1);
                    PH_FILL: begin
                        if (in_byte != fill) begin
                            pos     <= '0;
                            zcnt    <= '0;
                            verdict <= '{fin: 1'b1, ok: 1'b0};
                        end else begin
                            pos <= pos + POS_W'(1);
                        end
                    end
                    default: begin
                        if (int'(pos) == TOTAL - 1) begin
                            pos     <= '0;
                            zcnt    <= '0;
                            verdict <= '{fin: 1'b1, ok: (int'(zsum) >= MIN_ZEROS)};
                        end else begin
                            pos  <= pos + POS_W'(1);
                            zcnt <= zsum;
                        end
                    end
                endcase
            end
        end
    end

    assert_zero_bound_R4: assert property (@(posedge clk) disable iff (rst)
        int'(zcnt) <= WIN_BYTES * 8);

    assert_pos_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(pos) < TOTAL);

    assert_verdict_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        verdict.fin |=> !verdict.fin);

endmodule

// File: rtl/sig_retry_ctrl.sv
module sig_retry_ctrl
    import sigchk_pkg::*;
#(
    parameter int MAX_TRIES   = 5,
    parameter int FIRST_TRACK = 7,
    parameter int LAST_TRACK  = 10,
    localparam int TRK_W = $clog2(LAST_TRACK + 1),
    localparam int TRY_W = $clog2(MAX_TRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_in,
    input  verdict_t         verdict,
    output logic             busy,
    output logic [7:0]       fill,
    output logic             done,
    output logic             pass,
    output logic             fail,
    output logic [TRK_W-1:0] track_no,
    output logic [TRY_W-1:0] try_no
);
    logic clk_mode;

    assign fill = fill_value(clk_mode);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            busy     <= start;
            done     <= 1'b0;
            pass     <= 1'b0;
            fail     <= 1'b0;
            track_no <= TRK_W'(FIRST_TRACK);
            try_no   <= '0;
            clk_mode <= rst ? 1'b0 : mode_in;
        end else if (busy && verdict.fin) begin
            if (verdict.ok) begin
                busy <= 1'b0;
                done <= 1'b1;
                pass <= 1'b1;
            end else if (try_no == TRY_W'(MAX_TRIES - 1)) begin
                try_no <= '0;
                if (track_no == TRK_W'(LAST_TRACK)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    fail <= 1'b1;
                end else begin
                    track_no <= track_no + TRK_W'(1);
                end
            end else begin
                try_no <= try_no + TRY_W'(1);
            end
        end
    end

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    assert_done_match_R10: assert property (@(posedge clk) disable iff (rst)
        done == (pass || fail));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pass) && $stable(fail)
                              && $stable(track_no) && $stable(try_no)));

    assert_track_range_R6: assert property (@(posedge clk) disable iff (rst)
        (int'(track_no) >= FIRST_TRACK) && (int'(track_no) <= LAST_TRACK));

    assert_try_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(try_no) < MAX_TRIES);

    assert_fail_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (int'(track_no) == LAST_TRACK) && (try_no == '0));

endmodule

// File: rtl/sig_threshold_checker.sv
module sig_threshold_checker
    import sigchk_pkg::*;
#(
    parameter int SKIP_BYTES  = 64,
    parameter int FILL_BYTES  = 16,
    parameter int WIN_BYTES   = 32,
    parameter int MIN_ZEROS   = 204,
    parameter int MAX_TRIES   = 5,
    parameter int FIRST_TRACK = 7,
    parameter int LAST_TRACK  = 10,
    localparam int TRK_W = $clog2(LAST_TRACK + 1),
    localparam int TRY_W = $clog2(MAX_TRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             mode_clk,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             done,
    output logic             pass,
    output logic             fail,
    output logic [TRK_W-1:0] track_no,
    output logic [TRY_W-1:0] try_no
);
    verdict_t   verdict;
    logic       busy;
    logic [7:0] fill;

    sig_window_scan #(
        .SKIP_BYTES(SKIP_BYTES),
        .FILL_BYTES(FILL_BYTES),
        .WIN_BYTES (WIN_BYTES),
        .MIN_ZEROS (MIN_ZEROS)
    ) u_scan (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .en      (busy),
        .in_valid(in_valid),
        .in_byte (in_byte),
        .fill    (fill),
        .verdict (verdict)
    );

    sig_retry_ctrl #(
        .MAX_TRIES  (MAX_TRIES),
        .FIRST_TRACK(FIRST_TRACK),
        .LAST_TRACK (LAST_TRACK)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mode_in (mode_clk),
        .verdict (verdict),
        .busy    (busy),
        .fill    (fill),
        .done    (done),
        .pass    (pass),
        .fail    (fail),
        .track_no(track_no),
        .try_no  (try_no)
    );

endmodule

// File: tb/tb_sig_threshold_checker.sv
module tb_sig_threshold_checker;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic       mode_clk;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       done, pass, fail;
    logic [3:0] track_no;
    logic [2:0] try_no;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sig_threshold_checker dut (
        .clk(clk), .rst(rst), .start(start), .mode_clk(mode_clk),
        .in_valid(in_valid), .in_byte(in_byte),
        .done(done), .pass(pass), .fail(fail),
        .track_no(track_no), .try_no(try_no)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_start(input logic m);
        @(negedge clk);
        start    = 1'b1;
        mode_clk = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_skip(input logic [7:0] seed);
        for (int i = 0; i < 64; i++) send(seed ^ 8'(i * 37));
    endtask

    // full attempt: skip, 16 fill bytes, window holding exactly 'zeros' cleared bits
    task automatic send_attempt(input logic [7:0] seed, input logic [7:0] f, input int zeros);
        int left;
        int nz;
        send_skip(seed);
        for (int i = 0; i < 16; i++) send(f);
        left = zeros;
        for (int i = 0; i < 32; i++) begin
            nz = (left > 8) ? 8 : left;
            left -= nz;
            send((nz == 8) ? 8'h00 : 8'(8'hFF << nz));
        end
        idle(3);
    endtask

    task automatic send_abort(input logic [7:0] f, input logic [7:0] bad);
        send_skip(8'h3C);
        send(f);
        send(bad);
        idle(3);
    endtask

    task automatic expect_state(input string tag, input bit d, input bit p, input bit fl,
                                input int trk, input int tr);
        check(done == d, {tag, " done"}, done, d);
        check(pass == p, {tag, " pass"}, pass, p);
        check(fail == fl, {tag, " fail"}, fail, fl);
        check(int'(track_no) == trk, {tag, " track"}, track_no, trk);
        check(int'(try_no) == tr, {tag, " try"}, try_no, tr);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; mode_clk = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
        idle(3);
        rst = 1'b0;
        idle(1);
        expect_state("R1 reset", 0, 0, 0, 7, 0);
        // bytes before any start are not consumed
        send_attempt(8'h11, 8'hFF, 256);
        expect_state("R1 idle-before-start", 0, 0, 0, 7, 0);
    endtask

    task automatic t_pass_data_mode;
        do_start(1'b0);
        expect_state("R1 after start", 0, 0, 0, 7, 0);
        // skip region all zero bytes must not abort in data mode
        for (int i = 0; i < 64; i++) send(8'h00);
        for (int i = 0; i < 16; i++) send(8'hFF);
        for (int i = 0; i < 32; i++) send(8'h00);
        idle(3);
        expect_state("R2 R5 pass data", 1, 1, 0, 7, 0);
    endtask

    task automatic t_threshold;
        do_start(1'b0);
        send_attempt(8'h5A, 8'hFF, 203);
        expect_state("R4 203 zeros fails", 0, 0, 0, 7, 1);
        send_attempt(8'hA5, 8'hFF, 204);
        expect_state("R4 204 zeros passes", 1, 1, 0, 7, 1);
    endtask

    task automatic t_clock_mode;
        do_start(1'b1);
        mode_clk = 1'b0;  // must not matter after start
        send_attempt(8'hC3, 8'h00, 230);
        expect_state("R3 R9 clock mode pass", 1, 1, 0, 7, 0);
        // bytes while done
        send_attempt(8'h77, 8'hFF, 0);
        expect_state("R8 held after bytes", 1, 1, 0, 7, 0);
        // 8'hFF fill in clock mode aborts
        do_start(1'b1);
        send_abort(8'h00, 8'hFF);
        expect_state("R3 clock mode wrong fill", 0, 0, 0, 7, 1);
    endtask

    task automatic t_abort_resync;
        do_start(1'b0);
        send_abort(8'hFF, 8'hFE);
        expect_state("R3 abort on mismatch", 0, 0, 0, 7, 1);
        send_attempt(8'h99, 8'hFF, 256);
        expect_state("R3 next byte starts attempt", 1, 1, 0, 7, 1);
    endtask

    task automatic t_track_advance;
        do_start(1'b0);
        for (int i = 0; i < 5; i++) send_abort(8'hFF, 8'h00);
        expect_state("R6 track advance", 0, 0, 0, 8, 0);
        send_attempt(8'h21, 8'hFF, 210);
        expect_state("R5 R6 pass on track 8", 1, 1, 0, 8, 0);
    endtask

    task automatic t_final_fail;
        do_start(1'b0);
        for (int i = 0; i < 19; i++) send_abort(8'hFF, 8'h7F);
        expect_state("R6 before last", 0, 0, 0, 10, 4);
        send_attempt(8'h42, 8'hFF, 100);
        expect_state("R7 final fail", 1, 0, 1, 10, 0);
        send_attempt(8'h42, 8'hFF, 256);
        expect_state("R8 fail held", 1, 0, 1, 10, 0);
        do_start(1'b0);
        expect_state("R1 restart clears", 0, 0, 0, 7, 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_pass_data_mode();
        t_threshold();
        t_clock_mode();
        t_abort_resync();
        t_track_advance();
        t_final_fail();
        summary();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

endmodule